// File: doc/BRIEF.md
# Binary Vector-Matrix Correlation Core

This core stores a matrix of single-bit coefficients, one row per template, and, on each compute request, reports for every row how many column positions hold a one both in the stored row and in the presented input vector. Coefficients enter one bit at a time through a serial load register and are committed to a chosen row with a write request. A compute request carries a full input vector. One cycle later, a result strobe rises with every row count at once, each quantized to an 8-bit lane.

A hidden reference row that always holds zeros sees the same input vector as the template rows. Its count is subtracted from every row count, and each difference is clamped to the lane range. This removes any offset that all rows share. A small controller with two named states, `ST_COMPUTE` and `ST_REFRESH`, keeps count of accepted computes. After a fixed number of them, it inserts a one-cycle refresh and stalls the compute handshake. Successive refreshes take the even-numbered and the odd-numbered columns in turn. The transitions are: `ST_COMPUTE` to `ST_REFRESH` when the accepted compute that completes the interval is taken, `ST_REFRESH` to `ST_COMPUTE` unconditionally after one cycle, and `ST_COMPUTE` to itself otherwise.

Top module: `corr_core`

## Requirements
- R1: Lane m of `res_data` (bits 8m+7 down to 8m) equals the number of columns n for which stored bit W[m][n] and `cmp_vec[n]` are both one, minus the reference row count.
- R2: Each cycle with `sh_valid` high shifts `sh_bit` into the serial load register. After COLS such cycles, the first bit shifted in sits in column COLS-1 and the last one in column 0.
- R3: A write request copies the serial load register into row `wr_row` only. Every other row keeps its contents.
- R4: A compute leaves the stored coefficients unchanged, so repeating a compute with the same vector returns the same lanes.
- R5: The reference row holds all zeros and cannot be written. Each lane is the template count minus the reference count, clamped to the range 0 to 255.
- R6: `res_valid` is high in exactly the cycle after a compute is accepted (`cmp_req` and `cmp_ready` both high). `res_data` holds its value until the next accepted compute.
- R7: While `wr_req` is high, `cmp_ready` is low, so the write is performed and a compute requested in the same cycle is not taken.
- R8: After every REFRESH_INTERVAL accepted computes, `cmp_ready` is low for exactly one cycle (the `ST_REFRESH` state) and then returns high.
- R9: Refresh cycles alternate between the even column group and the odd column group, starting with even. A write requested during a refresh cycle is still performed.
- R10: After reset, `res_valid` is 0, `res_data` is 0, `cmp_ready` is 1 and every stored coefficient is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sh_valid | input | 1 | Shift one coefficient bit into the load register |
| sh_bit | input | 1 | Serial coefficient bit |
| wr_req | input | 1 | Commit the load register to a row |
| wr_row | input | RW | Target row of the write |
| cmp_req | input | 1 | Compute request |
| cmp_vec | input | COLS | Input vector, bit n drives column n |
| cmp_ready | output | 1 | Compute can be accepted this cycle |
| res_valid | output | 1 | Results of the previous accepted compute are valid |
| res_data | output | ROWS*OUT_W | Per-row clamped counts, lane m in bits OUT_W*m upward |

## Verification
Two functions can share a cycle: a write can arrive together with a compute, and a write can arrive in the refresh cycle. The bench drives `wr_req` and `cmp_req` together and checks three things: `cmp_ready` is low, no strobe follows, and a later compute shows that the write took effect. It also counts accepted computes until a stall is predicted and commits a row in that exact cycle. It then confirms that the stall lasts one cycle and that the new row content appears in the next result.

// File: rtl/corr_pkg.sv
package corr_pkg;

    typedef enum logic {
        ST_COMPUTE = 1'b0,
        ST_REFRESH = 1'b1
    } ctrl_state_e;

    // Clamp a signed difference into [0, hi].
    function automatic int clamp_range(input int v, input int hi);
        if (v < 0)       return 0;
        else if (v > hi) return hi;
        else             return v;
    endfunction

endpackage

// File: rtl/corr_shift.sv
module corr_shift #(
    parameter int COLS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sh_valid,
    input  logic            sh_bit,
    output logic [COLS-1:0] sr
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= '0;
        else if (sh_valid)
            sr <= {sr[COLS-2:0], sh_bit};
    end

endmodule

// File: rtl/corr_store.sv
module corr_store #(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    parameter int RW   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RW-1:0]        wr_row,
    input  logic [COLS-1:0]      wr_data,
    input  logic                 rf_en,
    input  logic                 rf_odd,
    output logic [ROWS*COLS-1:0] w_flat,
    output logic [COLS-1:0]      ref_bits
);

    logic [COLS-1:0] mem [ROWS];
    logic [COLS-1:0] ref_q;

    // Template rows: a write wins over the refresh restore of that row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                mem[r] <= '0;
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (wr_en && (wr_row == RW'(r))) begin
                    mem[r] <= wr_data;
                end else if (rf_en) begin
                    for (int c = 0; c < COLS; c++)
                        if ((c % 2) == int'(rf_odd))
                            mem[r][c] <= mem[r][c];
                end
            end
        end
    end

    // Reference row: cleared by reset, never addressed by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= '0;
    end

    assign ref_bits = ref_q;

    for (genvar g = 0; g < ROWS; g++) begin : g_flat
        assign w_flat[g*COLS +: COLS] = mem[g];
    end

endmodule

// File: rtl/corr_rowdot.sv
module corr_rowdot
    import corr_pkg::*;
#(
    parameter int COLS  = 32,
    parameter int OUT_W = 8
) (
    input  logic [COLS-1:0]  w_bits,
    input  logic [COLS-1:0]  ref_bits,
    input  logic [COLS-1:0]  vec,
    output logic [OUT_W-1:0] q
);

    localparam int CW   = $clog2(COLS + 1);
    localparam int MAXV = (2 ** OUT_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] rcnt;

    always_comb begin
        cnt  = '0;
        rcnt = '0;
        for (int c = 0; c < COLS; c++) begin
            cnt  = cnt  + CW'(w_bits[c]   & vec[c]);
            rcnt = rcnt + CW'(ref_bits[c] & vec[c]);
        end
        q = OUT_W'(clamp_range(int'(cnt) - int'(rcnt), MAXV));
    end

endmodule

// File: rtl/corr_ctrl.sv
module corr_ctrl
    import corr_pkg::*;
#(
    parameter int INTERVAL = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic cmp_req,
    output logic cmp_ready,
    output logic accept,
    output logic rf_go,
    output logic rf_odd
);

    localparam int CNT_W = $clog2(INTERVAL + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    ctrl_state_e     state, nxt;
    logic [CNT_W-1:0] cnt;
    logic            odd_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COMPUTE;
        else        state <= nxt;
    end

    // Interval counter and refresh group pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            odd_q <= 1'b0;
        end else begin
            if (accept)
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (rf_go)
                odd_q <= ~odd_q;
        end
    end

    // Outputs and next state
    always_comb begin
        cmp_ready = 1'b0;
        rf_go     = 1'b0;
        nxt       = state;
        unique case (state)
            ST_COMPUTE: begin
                cmp_ready = !wr_req;
                if (cmp_req && cmp_ready && (cnt == LAST))
                    nxt = ST_REFRESH;
            end
            ST_REFRESH: begin
                rf_go = 1'b1;
                nxt   = ST_COMPUTE;
            end
        endcase
        accept = cmp_req && cmp_ready;
        rf_odd = odd_q;
    end

endmodule

// File: rtl/corr_core.sv
module corr_core #(
    parameter int ROWS     = 16,
    parameter int COLS     = 32,
    parameter int OUT_W    = 8,
    parameter int INTERVAL = 8,
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sh_valid,
    input  logic                  sh_bit,
    input  logic                  wr_req,
    input  logic [RW-1:0]         wr_row,
    input  logic                  cmp_req,
    input  logic [COLS-1:0]       cmp_vec,
    output logic                  cmp_ready,
    output logic                  res_valid,
    output logic [ROWS*OUT_W-1:0] res_data
);

    logic [COLS-1:0]       load_bits;
    logic [ROWS*COLS-1:0]  w_flat;
    logic [COLS-1:0]       ref_bits;
    logic [ROWS*OUT_W-1:0] lanes;
    logic                  accept;
    logic                  refresh_go;
    logic                  refresh_odd;

    corr_shift #(.COLS(COLS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sh_valid (sh_valid),
        .sh_bit   (sh_bit),
        .sr       (load_bits)
    );

    corr_ctrl #(.INTERVAL(INTERVAL)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .cmp_req   (cmp_req),
        .cmp_ready (cmp_ready),
        .accept    (accept),
        .rf_go     (refresh_go),
        .rf_odd    (refresh_odd)
    );

    corr_store #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_req),
        .wr_row   (wr_row),
        .wr_data  (load_bits),
        .rf_en    (refresh_go),
        .rf_odd   (refresh_odd),
        .w_flat   (w_flat),
        .ref_bits (ref_bits)
    );

    for (genvar m = 0; m < ROWS; m++) begin : g_row
        corr_rowdot #(.COLS(COLS), .OUT_W(OUT_W)) u_dot (
            .w_bits   (w_flat[m*COLS +: COLS]),
            .ref_bits (ref_bits),
            .vec      (cmp_vec),
            .q        (lanes[m*OUT_W +: OUT_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= accept;
            if (accept)
                res_data <= lanes;
        end
    end

endmodule

// File: rtl/corr_core_chk.sv
module corr_core_chk #(
    parameter int ROWS  = 16,
    parameter int OUT_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_req,
    input logic                  cmp_req,
    input logic                  cmp_ready,
    input logic                  res_valid,
    input logic [ROWS*OUT_W-1:0] res_data,
    input logic                  refresh_go,
    input logic                  refresh_odd
);

    logic have_prev;
    logic prev_odd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_odd  <= 1'b0;
        end else if (refresh_go) begin
            have_prev <= 1'b1;
            prev_odd  <= refresh_odd;
        end
    end

    p_valid_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && cmp_ready) |=> res_valid);

    p_no_spurious_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_req && cmp_ready) |=> !res_valid);

    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_req && cmp_ready) |=> $stable(res_data));

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !cmp_ready);

    p_stall_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_ready && !wr_req) |=> (cmp_ready || wr_req));

    p_refresh_alternate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_go && have_prev) |-> (refresh_odd != prev_odd));

    p_first_refresh_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_go && !have_prev) |-> !refresh_odd);

endmodule

bind corr_core corr_core_chk #(.ROWS(ROWS), .OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (wr_req),
    .cmp_req     (cmp_req),
    .cmp_ready   (cmp_ready),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .refresh_go  (refresh_go),
    .refresh_odd (refresh_odd)
);

// File: tb/corr_core_tb.sv
`timescale 1ns/1ps
module corr_core_tb;

    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int IVL  = 4;
    localparam int WCOL = 260;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            sh_valid = 0, sh_bit = 0, wr_req = 0, cmp_req = 0;
    logic [1:0]      wr_row = 0;
    logic [COLS-1:0] cmp_vec = 0;
    logic            cmp_ready, res_valid;
    logic [ROWS*8-1:0] res_data;

    corr_core #(.ROWS(ROWS), .COLS(COLS), .OUT_W(8), .INTERVAL(IVL)) u_dut (
        .clk(clk), .rst_n(rst_n), .sh_valid(sh_valid), .sh_bit(sh_bit),
        .wr_req(wr_req), .wr_row(wr_row), .cmp_req(cmp_req), .cmp_vec(cmp_vec),
        .cmp_ready(cmp_ready), .res_valid(res_valid), .res_data(res_data)
    );

    logic            w_sh_valid = 0, w_sh_bit = 0, w_wr_req = 0, w_cmp_req = 0;
    logic [0:0]      w_wr_row = 0;
    logic [WCOL-1:0] w_cmp_vec = 0;
    logic            w_ready, w_valid;
    logic [15:0]     w_data;

    corr_core #(.ROWS(2), .COLS(WCOL), .OUT_W(8), .INTERVAL(IVL)) u_wide (
        .clk(clk), .rst_n(rst_n), .sh_valid(w_sh_valid), .sh_bit(w_sh_bit),
        .wr_req(w_wr_req), .wr_row(w_wr_row), .cmp_req(w_cmp_req), .cmp_vec(w_cmp_vec),
        .cmp_ready(w_ready), .res_valid(w_valid), .res_data(w_data)
    );

    int errors = 0;
    int checks = 0;
    int acc = 0;
    bit done = 0;
    logic [COLS-1:0] W [ROWS];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [COLS-1:0] v);
        int n = 0;
        for (int i = 0; i < COLS; i++) n += int'(v[i]);
        return n;
    endfunction

    // R2: first bit shifted lands in column COLS-1
    task automatic shift_in(input logic [COLS-1:0] pat);
        for (int i = 0; i < COLS; i++) begin
            @(negedge clk);
            sh_valid = 1'b1;
            sh_bit   = pat[COLS-1-i];
        end
        @(negedge clk);
        sh_valid = 1'b0;
    endtask

    // Caller is positioned just after a negedge.
    task automatic commit(input int row, input logic [COLS-1:0] pat);
        wr_req = 1'b1;
        wr_row = 2'(row);
        @(posedge clk);
        W[row] = pat;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    // R1/R6/R8: one accepted compute with full lane checks
    task automatic do_cmp(input logic [COLS-1:0] vec, input string req);
        @(negedge clk);
        cmp_req = 1'b1;
        cmp_vec = vec;
        #1;
        while (!cmp_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        acc++;
        @(negedge clk);
        cmp_req = 1'b0;
        check({req, " R6 valid"}, int'(res_valid), 1);
        for (int m = 0; m < ROWS; m++)
            check({req, " R1 lane"}, int'(res_data[m*8 +: 8]), popc(W[m] & vec));
        #1;
        check("R8 ready after compute", int'(cmp_ready), (acc % IVL != 0) ? 1 : 0);
    endtask

    initial begin
        for (int m = 0; m < ROWS; m++) W[m] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 valid", int'(res_valid), 0);
        check("R10 data", int'(res_data), 0);
        check("R10 ready", int'(cmp_ready), 1);
        do_cmp(8'hFF, "R10 zero matrix");

        // R2/R3: load asymmetric rows, one write each
        shift_in(8'hA5); commit(0, 8'hA5);
        shift_in(8'hFF); commit(1, 8'hFF);
        shift_in(8'h0F); commit(2, 8'h0F);
        shift_in(8'h81); commit(3, 8'h81);

        // R1/R8: exhaustive input sweep with periodic stalls
        for (int v = 0; v < 256; v++) do_cmp(8'(v), "R1 sweep");

        // R4: repeated compute returns identical lanes
        for (int k = 0; k < 3; k++) do_cmp(8'hA5, "R4 repeat");

        // R7: write and compute in the same cycle
        @(negedge clk);
        while (!cmp_ready) @(negedge clk);
        wr_req  = 1'b1;
        wr_row  = 2'd1;
        cmp_req = 1'b1;
        cmp_vec = 8'hFF;
        #1;
        check("R7 ready low on collision", int'(cmp_ready), 0);
        @(posedge clk);
        W[1] = 8'h81;
        @(negedge clk);
        wr_req  = 1'b0;
        cmp_req = 1'b0;
        check("R7 no strobe after collision", int'(res_valid), 0);
        do_cmp(8'hFF, "R7 write landed");

        // R9: commit a write exactly in a refresh cycle
        shift_in(8'h5A);
        do_cmp(8'h33, "R9 lead");
        while (acc % IVL != 0) do_cmp(8'h33, "R9 lead");
        check("R9 in refresh", int'(cmp_ready), 0);
        commit(2, 8'h5A);
        #1;
        check("R8 single stall", int'(cmp_ready), 1);
        do_cmp(8'hFF, "R9 write during refresh");
        do_cmp(8'h0F, "R9 write during refresh");

        // R5: clamp at 255 and zero reference on the wide instance
        for (int i = 0; i < WCOL; i++) begin
            @(negedge clk);
            w_sh_valid = 1'b1;
            w_sh_bit   = 1'b1;
        end
        @(negedge clk);
        w_sh_valid = 1'b0;
        w_wr_req   = 1'b1;
        w_wr_row   = 1'b0;
        @(negedge clk);
        w_wr_req   = 1'b0;
        #1;
        check("R5 wide ready", int'(w_ready), 1);
        w_cmp_req = 1'b1;
        w_cmp_vec = '1;
        @(negedge clk);
        w_cmp_req = 1'b0;
        check("R5 wide valid", int'(w_valid), 1);
        check("R5 saturate 255", int'(w_data[7:0]), 255);
        check("R5 zero row", int'(w_data[15:8]), 0);
        w_cmp_req = 1'b1;
        w_cmp_vec = '0;
        for (int i = 0; i < 200; i++) w_cmp_vec[i] = 1'b1;
        @(negedge clk);
        w_cmp_req = 1'b0;
        check("R5 unsaturated 200", int'(w_data[7:0]), 200);
        check("R5 zero row again", int'(w_data[15:8]), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule